// File: doc/BRIEF.md
# Nibble Command and Status Port Controller

This block is the controller end of a four-bit parallel link to a disc changer. A local client hands it a command of one or more nibbles over a valid/ready interface. The block opens a select window on the changer side and walks the nibbles out one at a time. For each nibble it runs a full four-phase request/acknowledge exchange. It closes the window once the last exchange has finished. If the changer stops answering, a cycle counter ends the command and the window is released.

In the other direction, the changer sends status nibbles with only a strobe. There is no flow control and a short capture deadline. The block synchronises the strobe and detects its falling edge, which latches the status nibble into a small queue. The client drains the queue over a second valid/ready interface. A nibble that arrives while the queue is full is dropped, and a sticky flag records the loss.

Top module: `nibble_link_master`

## Requirements
- R1: After reset: `chg_sel_n` and `chg_req_n` are 1, `cmd_ready` is 1, `st_valid` is 0, `st_overrun` is 0, and `cmd_done` and `cmd_timeout` are 0.
- R2: A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. Its nibble count is `cmd_len`; a value above `NIB_MAX` is treated as `NIB_MAX`. Nibble k is `cmd_data[4k+3:4k]`, and nibbles are sent in ascending k, one per handshake. `cmd_ready` stays low while a command is in progress.
- R3: `chg_sel_n` goes low on the cycle after a non-empty command is taken. It stays low until the last nibble's acknowledge has been released. `chg_req_n` is never low while `chg_sel_n` is high.
- R4: Each nibble appears on `chg_nib` at least one cycle before `chg_req_n` falls. It holds steady while `chg_req_n` is low. `chg_req_n` is released only after `chg_ack_n` is seen low. The next request waits until `chg_ack_n` is seen high again.
- R5: When a command completes normally, `cmd_done` pulses for one cycle, in the same cycle that `chg_sel_n` returns high.
- R6: If the awaited level of `chg_ack_n` has not arrived within `TO_CYC` cycles, the command is abandoned. `chg_sel_n` and `chg_req_n` go high, `cmd_timeout` pulses for one cycle, and `cmd_done` does not pulse.
- R7: A command with `cmd_len` = 0 is taken, and `cmd_done` pulses on the next cycle. `chg_sel_n` and `chg_req_n` do not move.
- R8: Each falling edge of `chg_stb_n` captures `chg_stat` exactly once, however long the strobe stays low. With the queue empty, `st_valid` rises on the third rising clock edge after the fall.
- R9: The status queue holds `Q_DEPTH` nibbles and delivers them in arrival order. While `st_valid` is high and `st_ready` is low, `st_valid` and `st_data` hold.
- R10: A nibble that arrives while the queue is full, with no pop in the same cycle, is discarded and the queued nibbles are left unchanged. `st_overrun` then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_data | input | NIB_MAX*4 | Command nibbles, nibble 0 in the low bits |
| cmd_len | input | LEN_W | Number of nibbles in the command |
| chg_nib | output | 4 | Command nibble bus to the changer |
| chg_sel_n | output | 1 | Active-low command window select |
| chg_req_n | output | 1 | Active-low nibble request |
| chg_ack_n | input | 1 | Active-low acknowledge from the changer (asynchronous) |
| cmd_done | output | 1 | One-cycle pulse on normal command completion |
| cmd_timeout | output | 1 | One-cycle pulse when a command is abandoned |
| chg_stb_n | input | 1 | Active-low status strobe (asynchronous) |
| chg_stat | input | 4 | Status nibble from the changer |
| st_valid | output | 1 | Status nibble available |
| st_ready | input | 1 | Client takes the status nibble |
| st_data | output | 4 | Oldest queued status nibble |
| st_overrun | output | 1 | Sticky flag: a status nibble was lost |

## Verification
The assertions rely on the changer moving `chg_ack_n` only in answer to a change of `chg_req_n`. They also rely on `chg_stat` being steady from before the strobe falls until after it rises, with each strobe level lasting at least two clock cycles so the synchroniser sees it. The bench's changer model has exactly this behaviour: its acknowledge follows the request after a programmable delay, or else stays silent or stuck low to force aborts. Each strobe phase is held for four cycles, and the status value is set up together with the falling edge.

// File: rtl/nlm_pkg.sv
package nlm_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_SETUP = 2'd1,
    CS_REQ   = 2'd2,
    CS_REL   = 2'd3
  } cmd_state_e;
endpackage

// File: rtl/nlm_sync.sv
module nlm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/nlm_cmd_seq.sv
module nlm_cmd_seq
  import nlm_pkg::*;
#(
  parameter int NIB_MAX = 8,
  parameter int TO_CYC  = 1000,
  parameter int LEN_W   = $clog2(NIB_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NIB_MAX*4-1:0] in_data,
  input  logic [LEN_W-1:0]     in_len,
  input  logic                 ack_s,
  output logic [3:0]           nib_o,
  output logic                 sel_n_o,
  output logic                 req_n_o,
  output logic                 done_o,
  output logic                 timeout_o
);
  localparam int DW = NIB_MAX * 4;
  localparam int TO_W = $clog2(TO_CYC + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TO_CYC - 1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(NIB_MAX);

  cmd_state_e       st, nxt;
  logic [DW-1:0]    sh;
  logic [LEN_W-1:0] left;
  logic [TO_W-1:0]  wait_q;
  logic [LEN_W-1:0] eff_len;
  logic             load, adv, fin, abort;

  assign eff_len  = (in_len > LEN_CAP) ? LEN_CAP : in_len;
  assign in_ready = (st == CS_IDLE);
  assign nib_o    = sh[3:0];

  always_comb begin
    nxt   = st;
    load  = 1'b0;
    adv   = 1'b0;
    fin   = 1'b0;
    abort = 1'b0;
    unique case (st)
      CS_IDLE: begin
        if (in_valid) begin
          if (eff_len == '0) begin
            fin = 1'b1;
          end else begin
            nxt  = CS_SETUP;
            load = 1'b1;
          end
        end
      end
      CS_SETUP: if (ack_s) nxt = CS_REQ;
      CS_REQ:   if (!ack_s) nxt = CS_REL;
      CS_REL: begin
        if (ack_s) begin
          if (left == LEN_W'(1)) begin
            nxt = CS_IDLE;
            fin = 1'b1;
          end else begin
            nxt = CS_SETUP;
            adv = 1'b1;
          end
        end
      end
      default: nxt = CS_IDLE;
    endcase
    if (st != CS_IDLE && nxt == st && wait_q == TO_LAST) begin
      nxt   = CS_IDLE;
      abort = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CS_IDLE;
      sh        <= '0;
      left      <= '0;
      wait_q    <= '0;
      sel_n_o   <= 1'b1;
      req_n_o   <= 1'b1;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st || st == CS_IDLE) wait_q <= '0;
      else                            wait_q <= wait_q + 1'b1;
      if (load) begin
        sh   <= in_data;
        left <= eff_len;
      end else if (adv) begin
        sh   <= sh >> 4;
        left <= left - 1'b1;
      end
      sel_n_o   <= (nxt == CS_IDLE);
      req_n_o   <= (nxt != CS_REQ);
      done_o    <= fin;
      timeout_o <= abort;
    end
  end
endmodule

// File: rtl/nlm_stat_q.sv
module nlm_stat_q #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_s,
  input  logic [3:0] dat_s,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [3:0] out_data,
  output logic       overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [3:0]  mem [DEPTH];
  logic [AW-1:0] wr, rd;
  logic [AW:0] cnt;
  logic        stb_prev, fall, full, pop, push;

  assign fall      = stb_prev && !stb_s;
  assign full      = (cnt == FULL_CNT);
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;
  assign push      = fall && (!full || pop);
  assign out_data  = mem[rd];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mem[i] <= '0;
      else if (push && wr == AW'(i))   mem[i] <= dat_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev <= 1'b1;
      wr       <= '0;
      rd       <= '0;
      cnt      <= '0;
      overrun  <= 1'b0;
    end else begin
      stb_prev <= stb_s;
      if (push) wr <= (wr == AW'(DEPTH-1)) ? '0 : wr + 1'b1;
      if (pop)  rd <= (rd == AW'(DEPTH-1)) ? '0 : rd + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (fall && !push) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/nibble_link_master.sv
module nibble_link_master #(
  parameter int NIB_MAX = 8,
  parameter int TO_CYC  = 1000,
  parameter int Q_DEPTH = 4,
  parameter int LEN_W   = $clog2(NIB_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [NIB_MAX*4-1:0] cmd_data,
  input  logic [LEN_W-1:0]     cmd_len,
  output logic [3:0]           chg_nib,
  output logic                 chg_sel_n,
  output logic                 chg_req_n,
  input  logic                 chg_ack_n,
  output logic                 cmd_done,
  output logic                 cmd_timeout,
  input  logic                 chg_stb_n,
  input  logic [3:0]           chg_stat,
  output logic                 st_valid,
  input  logic                 st_ready,
  output logic [3:0]           st_data,
  output logic                 st_overrun
);
  logic       ack_s;
  logic [4:0] stat_s;

  nlm_sync #(.W(1), .INIT(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(chg_ack_n), .q(ack_s)
  );

  nlm_sync #(.W(5), .INIT(5'b10000)) u_stat_sync (
    .clk(clk), .rst_n(rst_n), .d({chg_stb_n, chg_stat}), .q(stat_s)
  );

  nlm_cmd_seq #(.NIB_MAX(NIB_MAX), .TO_CYC(TO_CYC), .LEN_W(LEN_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid), .in_ready(cmd_ready),
    .in_data(cmd_data), .in_len(cmd_len),
    .ack_s(ack_s),
    .nib_o(chg_nib), .sel_n_o(chg_sel_n), .req_n_o(chg_req_n),
    .done_o(cmd_done), .timeout_o(cmd_timeout)
  );

  nlm_stat_q #(.DEPTH(Q_DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .stb_s(stat_s[4]), .dat_s(stat_s[3:0]),
    .out_valid(st_valid), .out_ready(st_ready),
    .out_data(st_data), .overrun(st_overrun)
  );
endmodule

// File: rtl/nlm_checker.sv
module nlm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic [3:0] chg_nib,
  input logic       chg_sel_n,
  input logic       chg_req_n,
  input logic       cmd_done,
  input logic       cmd_timeout,
  input logic       st_valid,
  input logic       st_ready,
  input logic [3:0] st_data,
  input logic       st_overrun
);
  p_idle_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> chg_sel_n);

  p_req_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_req_n |-> !chg_sel_n);

  p_nib_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_req_n |-> $stable(chg_nib));

  p_done_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> chg_sel_n && !cmd_timeout);

  p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_timeout |-> chg_sel_n && chg_req_n);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_overrun |=> st_overrun);
endmodule

bind nibble_link_master nlm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .chg_nib(chg_nib),
  .chg_sel_n(chg_sel_n), .chg_req_n(chg_req_n), .cmd_done(cmd_done),
  .cmd_timeout(cmd_timeout), .st_valid(st_valid), .st_ready(st_ready),
  .st_data(st_data), .st_overrun(st_overrun)
);

// File: tb/nibble_link_master_test.sv
module nibble_link_master_test;
  localparam int PERIOD = 10;
  localparam int NMAX = 4;
  localparam int TOC = 20;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [2:0] cmd_len = '0;
  logic [3:0] chg_nib;
  logic chg_sel_n, chg_req_n;
  logic chg_ack_n = 1'b1;
  logic cmd_done, cmd_timeout;
  logic chg_stb_n = 1'b1;
  logic [3:0] chg_stat = '0;
  logic st_valid;
  logic st_ready = 1'b0;
  logic [3:0] st_data;
  logic st_overrun;

  always #(PERIOD/2) clk = ~clk;

  nibble_link_master #(.NIB_MAX(NMAX), .TO_CYC(TOC), .Q_DEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_len(cmd_len), .chg_nib(chg_nib),
    .chg_sel_n(chg_sel_n), .chg_req_n(chg_req_n), .chg_ack_n(chg_ack_n),
    .cmd_done(cmd_done), .cmd_timeout(cmd_timeout), .chg_stb_n(chg_stb_n),
    .chg_stat(chg_stat), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .st_overrun(st_overrun)
  );

  int checks = 0;
  int errors = 0;

  // changer model: 0 follows request after dly, 1 silent, 2 sticks low
  int ack_mode = 0;
  int ack_dly = 1;
  int ack_cnt = 0;
  always @(negedge clk) begin
    if (ack_mode == 1) begin
      ack_cnt <= 0;
    end else if (ack_mode == 2) begin
      if (!chg_req_n) chg_ack_n <= 1'b0;
    end else if (chg_ack_n != chg_req_n) begin
      if (ack_cnt >= ack_dly) begin
        chg_ack_n <= chg_req_n;
        ack_cnt <= 0;
      end else begin
        ack_cnt <= ack_cnt + 1;
      end
    end else begin
      ack_cnt <= 0;
    end
  end

  // observers
  logic [3:0] rec [0:255];
  int rec_n = 0;
  logic [3:0] popped [0:255];
  int pop_n = 0;
  int done_cnt = 0, to_cnt = 0, viol_sel = 0, viol_nib = 0;
  logic prev_req = 1'b1;
  logic [3:0] prev_nib = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && !chg_req_n) begin
        rec[rec_n[7:0]] <= chg_nib;
        rec_n <= rec_n + 1;
      end
      if (!chg_req_n && chg_sel_n) viol_sel <= viol_sel + 1;
      if (!chg_req_n && !prev_req && chg_nib != prev_nib) viol_nib <= viol_nib + 1;
      if (cmd_done) done_cnt <= done_cnt + 1;
      if (cmd_timeout) to_cnt <= to_cnt + 1;
      if (st_valid && st_ready) begin
        popped[pop_n[7:0]] <= st_data;
        pop_n <= pop_n + 1;
      end
    end
    prev_req <= chg_req_n;
    prev_nib <= chg_nib;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int l, input int p, input int i);
    return 4'((l * 5 + i * 3 + p * 7 + 1) & 15);
  endfunction

  // send one command, wait for its end; returns cycles waited
  task automatic send(input logic [15:0] d, input logic [2:0] l, output int waited);
    int d0, t0;
    d0 = done_cnt;
    t0 = to_cnt;
    waited = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = d;
    cmd_len = l;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (l == 0) begin
      chk(cmd_done == 1'b1 && chg_sel_n == 1'b1, "R7 empty command done pulse", int'(cmd_done), 1);
    end else begin
      chk(cmd_ready == 1'b0, "R2 ready low while busy", int'(cmd_ready), 0);
      chk(chg_sel_n == 1'b0 && chg_req_n == 1'b1, "R3 select falls before request",
          int'({chg_sel_n, chg_req_n}), 1);
    end
    while (done_cnt == d0 && to_cnt == t0 && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input logic [3:0] v);
    @(negedge clk);
    chg_stat = v;
    chg_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    chg_stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    st_ready = 1'b1;
    repeat (8) @(negedge clk);
    st_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_tests();
    int w, r0, d0, t0, p0;
    logic [3:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(chg_sel_n && chg_req_n && cmd_ready && !st_valid && !st_overrun && !cmd_done && !cmd_timeout,
        "R1 reset outputs", int'({chg_sel_n, chg_req_n, cmd_ready, st_valid, st_overrun}), 28);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // command sweep: lengths 0..7 (above 4 clamps), three patterns and ack delays
    for (int l = 0; l < 8; l++) begin
      for (int p = 0; p < 3; p++) begin
        logic [15:0] d;
        int n;
        for (int i = 0; i < 4; i++) d[i*4 +: 4] = pat(l, p, i);
        n = (l > NMAX) ? NMAX : l;
        ack_dly = p + 1;
        r0 = rec_n;
        d0 = done_cnt;
        t0 = to_cnt;
        send(d, 3'(l), w);
        chk(rec_n - r0 == n, "R2 nibble count per command", rec_n - r0, n);
        for (int i = 0; i < n; i++)
          chk(rec[(r0 + i) & 255] == d[i*4 +: 4], "R2 nibble order and value",
              int'(rec[(r0 + i) & 255]), int'(d[i*4 +: 4]));
        chk(done_cnt - d0 == 1, "R5 done pulse once", done_cnt - d0, 1);
        chk(to_cnt == t0, "R6 no timeout on answered command", to_cnt - t0, 0);
        chk(chg_sel_n == 1'b1 && cmd_ready == 1'b1, "R3 select released at end", int'(chg_sel_n), 1);
      end
    end
    chk(viol_sel == 0, "R3 request outside select", viol_sel, 0);
    chk(viol_nib == 0, "R4 nibble moved during request", viol_nib, 0);

    // R6: silent changer, abort while waiting for acknowledge
    ack_mode = 1;
    r0 = rec_n; d0 = done_cnt; t0 = to_cnt;
    send(16'h4321, 3'd3, w);
    chk(to_cnt - t0 == 1, "R6 timeout pulse silent", to_cnt - t0, 1);
    chk(done_cnt == d0, "R6 no done on abort", done_cnt - d0, 0);
    chk(w <= TOC + 8, "R6 abort within limit", w, TOC + 8);
    chk(rec_n - r0 == 1, "R6 only first request issued", rec_n - r0, 1);
    chk(chg_sel_n && chg_req_n, "R6 lines released", int'({chg_sel_n, chg_req_n}), 3);

    // R6: acknowledge stuck low, abort while waiting for release
    ack_mode = 2;
    t0 = to_cnt; d0 = done_cnt; r0 = rec_n;
    send(16'h00A5, 3'd2, w);
    chk(to_cnt - t0 == 1, "R6 timeout pulse stuck", to_cnt - t0, 1);
    chk(rec_n - r0 == 1, "R6 stuck single request", rec_n - r0, 1);
    chk(chg_sel_n && chg_req_n, "R6 lines released after stuck", int'({chg_sel_n, chg_req_n}), 3);
    ack_mode = 0;
    ack_dly = 1;
    repeat (6) @(negedge clk);

    // R4: recovery after abort, full-length command
    r0 = rec_n; d0 = done_cnt;
    send(16'h9C3E, 3'd4, w);
    chk(done_cnt - d0 == 1, "R4 command after abort completes", done_cnt - d0, 1);
    chk(rec_n - r0 == 4 && rec[(r0 + 3) & 255] == 4'h9, "R4 recovered nibbles",
        int'(rec[(r0 + 3) & 255]), 9);

    // R8: exact capture latency, queue empty
    @(negedge clk);
    chg_stat = 4'h6;
    chg_stb_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(st_valid == 1'b0, "R8 not valid after two edges", int'(st_valid), 0);
    @(negedge clk);
    chk(st_valid == 1'b1 && st_data == 4'h6, "R8 valid after three edges", int'(st_data), 6);
    repeat (6) @(negedge clk);
    chg_stb_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: hold under back-pressure
    held = st_data;
    repeat (3) @(negedge clk);
    chk(st_valid && st_data == held, "R9 output held without ready", int'(st_data), int'(held));

    // fill the queue, then one more for overrun
    strobe(4'hB);
    strobe(4'h2);
    strobe(4'hD);
    chk(st_overrun == 1'b0, "R10 no overrun at exactly full", int'(st_overrun), 0);
    strobe(4'hF);
    chk(st_overrun == 1'b1, "R10 overrun on full queue", int'(st_overrun), 1);
    p0 = pop_n;
    drain();
    chk(pop_n - p0 == QD, "R8 one entry per strobe", pop_n - p0, QD);
    chk(popped[p0 & 255] == 4'h6 && popped[(p0 + 1) & 255] == 4'hB &&
        popped[(p0 + 2) & 255] == 4'h2 && popped[(p0 + 3) & 255] == 4'hD,
        "R9 order kept and R10 dropped nibble absent", int'(popped[(p0 + 3) & 255]), 13);
    chk(st_valid == 1'b0 && st_overrun == 1'b1, "R10 overrun sticky after drain",
        int'(st_overrun), 1);

    // R8: sweep every status value with the client ready
    @(negedge clk);
    st_ready = 1'b1;
    p0 = pop_n;
    for (int v = 0; v < 16; v++) strobe(4'(v));
    repeat (4) @(negedge clk);
    st_ready = 1'b0;
    chk(pop_n - p0 == 16, "R8 sweep count", pop_n - p0, 16);
    for (int v = 0; v < 16; v++)
      chk(popped[(p0 + v) & 255] == 4'(v), "R8 sweep value", int'(popped[(p0 + v) & 255]), v);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule